// File: doc/BRIEF.md
# Supervisory Watchdog and Reset Generator

This block is the clocked controller of a processor supervisor. Analog comparators elsewhere on the chip reduce the supply and power-fail conditions to four digital flags: supply above the reset threshold, supply below the switchover level, supply below the backup battery, and power-fail sense input below its reference. The block turns these flags and the processor's watchdog input into three outputs. The first is a stretched processor reset, active-low by default or active-high through a parameter. The second is an active-low power-fail warning. The third is a select line that steers the memory supply path to the backup battery.

The reset path is a three-state machine. `ST_HOLD` is entered whenever the supply is below the reset threshold. `ST_STRETCH` runs a fixed-length pulse. `ST_RUN` is the only state in which reset is released. The transitions are:
- HOLD to STRETCH when the supply recovers.
- STRETCH to RUN when the pulse count completes.
- STRETCH or RUN to HOLD on a supply drop.
- RUN to STRETCH on watchdog expiry.

The watchdog input passes through a two-flop synchronizer and an edge detector. Either edge clears the watchdog counter, and so does any state other than `ST_RUN`. The watchdog has no enable. The battery path is a two-state machine. `PATH_MAIN` moves to `PATH_BATT` when the supply is below both the switchover level and the battery. `PATH_BATT` returns to `PATH_MAIN` only when the supply is back above the reset threshold. Durations are parameters in clock cycles, computed by default from a clock-frequency parameter: 1600 ms for the watchdog and 200 ms for the pulse.

Top module: `supervisor_ctrl`

## Requirements
- R1: While `rst_n` is low and after it is released with `vcc_ok` low, the reset output is active and `bat_sel` is 0.
- R2: Each rising edge and each falling edge of `wdi` restarts the watchdog. A `wdi` that changes at intervals shorter than `WD_CYCLES`, counting both edge directions, never causes a reset. No input can disable the watchdog.
- R3: The watchdog counter is held at zero while reset is active. After a reset pulse ends with `wdi` constant, the next watchdog reset follows exactly `WD_CYCLES` edges after reset releases.
- R4: If `wdi` changes once and then stays constant, reset asserts at the `WD_CYCLES+3`-th rising clock edge after the change: two synchronizer edges, one edge to clear the counter, then `WD_CYCLES` edges.
- R5: A watchdog reset keeps the reset output active for exactly `PULSE_CYCLES` clock cycles.
- R6: When `vcc_ok` is 0 at a rising edge, reset is active after that edge and stays active while `vcc_ok` is 0.
- R7: After `vcc_ok` returns to 1, reset is released at the `PULSE_CYCLES+1`-th rising edge after the first edge that samples it high. A drop during the stretch restarts the whole stretch.
- R8: With `ACTIVE_HIGH`=1 the reset output is the exact bitwise inverse of the `ACTIVE_HIGH`=0 output for the same inputs.
- R9: `pf_n` is 0 combinationally whenever `pfi_low` or `vcc_below_sw` is 1, and is 1 otherwise.
- R10: `bat_sel` becomes 1 at the edge after `vcc_below_sw` and `vcc_below_bat` are both 1. It returns to 0 only at the edge after `vcc_ok` is 1. Neither flag alone sets it, and clearing them does not release it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| vcc_ok | input | 1 | Supply is above the reset threshold |
| vcc_below_sw | input | 1 | Supply is below the switchover level |
| vcc_below_bat | input | 1 | Supply is below the backup battery voltage |
| pfi_low | input | 1 | Power-fail sense input is below its reference |
| wdi | input | 1 | Watchdog input from the processor, asynchronous |
| sup_rst | output | 1 | Stretched processor reset, polarity set by `ACTIVE_HIGH` |
| pf_n | output | 1 | Power-fail warning, 0 on failure |
| bat_sel | output | 1 | 1 selects the battery supply path |

## Verification
Results fall due at different times. `pf_n` follows its flags in the same cycle. `bat_sel` and the assertion of reset on a supply drop follow one rising edge after the flag changes. Release after supply recovery comes `PULSE_CYCLES+1` edges after the flag rises. A watchdog expiry appears `WD_CYCLES+3` edges after the last `wdi` change. The bench drives every input on the falling clock edge and samples on later falling edges. It counts exactly these edge numbers from each stimulus and checks the output both one cycle before and in the cycle where it is due to change.

// File: rtl/sup_pkg.sv
package sup_pkg;

    typedef enum logic [1:0] {
        ST_HOLD    = 2'd0,
        ST_STRETCH = 2'd1,
        ST_RUN     = 2'd2
    } rst_state_t;

    typedef enum logic {
        PATH_MAIN = 1'b0,
        PATH_BATT = 1'b1
    } path_state_t;

    function automatic int ms_to_cycles(input int clk_hz, input int ms);
        return (clk_hz / 1000) * ms;
    endfunction

endpackage

// File: rtl/sup_wdi_edge.sv
module sup_wdi_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wdi,
    output logic wdi_edge
);
    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q[0] <= 1'b0;
                else        sync_q[0] <= wdi;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q[i] <= 1'b0;
                else        sync_q[i] <= sync_q[i-1];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sync_q[STAGES-1];
    end

    assign wdi_edge = sync_q[STAGES-1] ^ prev_q;

endmodule

// File: rtl/sup_wdog.sv
module sup_wdog #(
    parameter int WD_CYCLES = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wdi_edge,
    input  logic hold,
    output logic expire
);
    localparam int CW = $clog2(WD_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(WD_CYCLES - 1);

    logic [CW-1:0] cnt_q;
    logic          clear;

    assign clear = hold | wdi_edge;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             cnt_q <= '0;
        else if (clear)         cnt_q <= '0;
        else if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
    end

    assign expire = (cnt_q == LAST) & ~clear;

    // R4
    wd_count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);

    // R3
    wd_hold_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> (cnt_q == '0));

endmodule

// File: rtl/sup_rst_fsm.sv
module sup_rst_fsm
    import sup_pkg::*;
#(
    parameter int PULSE_CYCLES = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic vcc_ok,
    input  logic wd_expire,
    output logic rst_active
);
    localparam int PW = $clog2(PULSE_CYCLES + 1);
    localparam logic [PW-1:0] PLAST = PW'(PULSE_CYCLES - 1);

    rst_state_t    state_q, state_d;
    logic [PW-1:0] pcnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_HOLD;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HOLD: begin
                if (vcc_ok) state_d = ST_STRETCH;
            end
            ST_STRETCH: begin
                if (!vcc_ok)              state_d = ST_HOLD;
                else if (pcnt_q == PLAST) state_d = ST_RUN;
            end
            ST_RUN: begin
                if (!vcc_ok)        state_d = ST_HOLD;
                else if (wd_expire) state_d = ST_STRETCH;
            end
            default: state_d = ST_HOLD;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            pcnt_q <= '0;
        else if (state_q == ST_STRETCH && state_d == ST_STRETCH)
            pcnt_q <= pcnt_q + 1'b1;
        else
            pcnt_q <= '0;
    end

    always_comb begin
        rst_active = (state_q != ST_RUN);
    end

    // R6
    hold_on_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !vcc_ok |=> (state_q == ST_HOLD));

    // R5
    wd_to_stretch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && vcc_ok && wd_expire) |=> (state_q == ST_STRETCH));

    // R7
    stretch_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STRETCH) |-> (pcnt_q < PW'(PULSE_CYCLES)));

endmodule

// File: rtl/sup_batt_fsm.sv
module sup_batt_fsm
    import sup_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic vcc_ok,
    input  logic vcc_below_sw,
    input  logic vcc_below_bat,
    output logic bat_sel
);
    path_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PATH_MAIN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PATH_MAIN: if (vcc_below_sw && vcc_below_bat) state_d = PATH_BATT;
            PATH_BATT: if (vcc_ok)                        state_d = PATH_MAIN;
            default:   state_d = PATH_MAIN;
        endcase
    end

    always_comb begin
        bat_sel = (state_q == PATH_BATT);
    end

    // R10
    batt_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PATH_BATT && !vcc_ok) |=> (state_q == PATH_BATT));

    // R10
    main_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PATH_MAIN && !(vcc_below_sw && vcc_below_bat)) |=> (state_q == PATH_MAIN));

endmodule

// File: rtl/supervisor_ctrl.sv
module supervisor_ctrl
    import sup_pkg::*;
#(
    parameter int CLK_HZ       = 100_000_000,
    parameter int WD_MS        = 1600,
    parameter int PULSE_MS     = 200,
    parameter int WD_CYCLES    = ms_to_cycles(CLK_HZ, WD_MS),
    parameter int PULSE_CYCLES = ms_to_cycles(CLK_HZ, PULSE_MS),
    parameter int SYNC_STAGES  = 2,
    parameter bit ACTIVE_HIGH  = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic vcc_ok,
    input  logic vcc_below_sw,
    input  logic vcc_below_bat,
    input  logic pfi_low,
    input  logic wdi,
    output logic sup_rst,
    output logic pf_n,
    output logic bat_sel
);
    logic wdi_edge;
    logic wd_expire;
    logic rst_active;

    sup_wdi_edge #(.STAGES(SYNC_STAGES)) u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .wdi      (wdi),
        .wdi_edge (wdi_edge)
    );

    sup_wdog #(.WD_CYCLES(WD_CYCLES)) u_wdog (
        .clk      (clk),
        .rst_n    (rst_n),
        .wdi_edge (wdi_edge),
        .hold     (rst_active),
        .expire   (wd_expire)
    );

    sup_rst_fsm #(.PULSE_CYCLES(PULSE_CYCLES)) u_rst (
        .clk        (clk),
        .rst_n      (rst_n),
        .vcc_ok     (vcc_ok),
        .wd_expire  (wd_expire),
        .rst_active (rst_active)
    );

    sup_batt_fsm u_batt (
        .clk           (clk),
        .rst_n         (rst_n),
        .vcc_ok        (vcc_ok),
        .vcc_below_sw  (vcc_below_sw),
        .vcc_below_bat (vcc_below_bat),
        .bat_sel       (bat_sel)
    );

    if (ACTIVE_HIGH) begin : g_pol_hi
        assign sup_rst = rst_active;
    end else begin : g_pol_lo
        assign sup_rst = ~rst_active;
    end

    assign pf_n = ~(pfi_low | vcc_below_sw);

    // R9
    pf_sense_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pfi_low |-> !pf_n);

    // R9
    pf_switch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vcc_below_sw |-> !pf_n);

endmodule

// File: tb/supervisor_ctrl_tb_top.sv
module supervisor_ctrl_tb_top;

    localparam int WD  = 40;
    localparam int PUL = 10;

    logic clk = 1'b0;
    logic rst_n, vcc_ok, vcc_below_sw, vcc_below_bat, pfi_low, wdi;
    logic rst_lo, rst_hi, pf_n, bat_sel, pf_n_hi, bat_sel_hi;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    supervisor_ctrl #(.WD_CYCLES(WD), .PULSE_CYCLES(PUL), .ACTIVE_HIGH(1'b0)) dut_i (
        .clk(clk), .rst_n(rst_n), .vcc_ok(vcc_ok), .vcc_below_sw(vcc_below_sw),
        .vcc_below_bat(vcc_below_bat), .pfi_low(pfi_low), .wdi(wdi),
        .sup_rst(rst_lo), .pf_n(pf_n), .bat_sel(bat_sel)
    );

    supervisor_ctrl #(.WD_CYCLES(WD), .PULSE_CYCLES(PUL), .ACTIVE_HIGH(1'b1)) dut_hi_i (
        .clk(clk), .rst_n(rst_n), .vcc_ok(vcc_ok), .vcc_below_sw(vcc_below_sw),
        .vcc_below_bat(vcc_below_bat), .pfi_low(pfi_low), .wdi(wdi),
        .sup_rst(rst_hi), .pf_n(pf_n_hi), .bat_sel(bat_sel_hi)
    );

    // fields: [5] vcc_ok [4] below_sw [3] below_bat [2] pfi_low [1] exp pf_n [0] exp bat_sel
    localparam logic [5:0] VEC [10] = '{
        6'b100010, 6'b100100, 6'b010000, 6'b011001, 6'b000011,
        6'b001101, 6'b100010, 6'b001010, 6'b011101, 6'b101010
    };

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    task automatic chk_rst(input string tag, input logic exp_active);
        chk(tag, rst_lo, ~exp_active);
        chk("R8 polarity", rst_hi, exp_active);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog timeout actual=hung expected=finished");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; vcc_ok = 1'b0; vcc_below_sw = 1'b0;
        vcc_below_bat = 1'b0; pfi_low = 1'b0; wdi = 1'b0;
        tick(3);
        chk_rst("R1 reset during rst_n", 1'b1);
        chk("R1 bat_sel during rst_n", bat_sel, 1'b0);
        rst_n = 1'b1;
        tick(3);
        chk_rst("R1 reset after release", 1'b1);
        chk("R1 bat_sel after release", bat_sel, 1'b0);

        // table walk: R9 power-fail and R10 battery path
        for (int i = 0; i < 10; i++) begin
            vcc_ok        = VEC[i][5];
            vcc_below_sw  = VEC[i][4];
            vcc_below_bat = VEC[i][3];
            pfi_low       = VEC[i][2];
            #1;
            chk($sformatf("R9 pf_n vec %0d", i), pf_n, VEC[i][1]);
            tick(1);
            chk($sformatf("R10 bat_sel vec %0d", i), bat_sel, VEC[i][0]);
        end

        // R7 power-up stretch
        vcc_ok = 1'b0; vcc_below_sw = 1'b0; vcc_below_bat = 1'b0; pfi_low = 1'b0;
        tick(2);
        chk_rst("R6 held while low", 1'b1);
        vcc_ok = 1'b1;
        tick(PUL);
        chk_rst("R7 still stretched", 1'b1);
        tick(1);
        chk_rst("R7 released", 1'b0);

        // R2 both edges restart the watchdog
        for (int i = 0; i < 8; i++) begin
            wdi = ~wdi;
            tick(30);
            chk_rst("R2 toggling keeps run", 1'b0);
        end

        // R4 timeout, R5 pulse width, R3 full restart
        wdi = ~wdi;
        tick(WD + 2);
        chk_rst("R4 before expiry", 1'b0);
        tick(1);
        chk_rst("R4 expiry asserts", 1'b1);
        tick(PUL - 1);
        chk_rst("R5 pulse last cycle", 1'b1);
        tick(1);
        chk_rst("R5 pulse ended", 1'b0);
        tick(WD - 1);
        chk_rst("R3 full period after pulse", 1'b0);
        tick(1);
        chk_rst("R3 second expiry", 1'b1);
        tick(PUL);
        chk_rst("R5 second pulse ended", 1'b0);

        // R6 brown-out in run
        wdi = ~wdi;
        tick(5);
        vcc_ok = 1'b0;
        tick(1);
        chk_rst("R6 drop asserts", 1'b1);
        tick(60);
        chk_rst("R6 stays while low", 1'b1);

        // R7 dip during stretch restarts it
        vcc_ok = 1'b1;
        tick(5);
        chk_rst("R7 mid stretch", 1'b1);
        vcc_ok = 1'b0;
        tick(1);
        vcc_ok = 1'b1;
        tick(PUL);
        chk_rst("R7 restarted stretch", 1'b1);
        tick(1);
        chk_rst("R7 restarted release", 1'b0);

        finish_run();
    end

endmodule